// File: doc/BRIEF.md
# Dual-Clock Serial-to-Parallel Latch

This block turns a serial bit stream into a parallel word in two stages. A chain of shift stages takes one new bit on every rising edge of the shift clock. A separate storage register copies the whole chain at once on a rising edge of its own clock. Software-free glue logic can therefore shift a complete word in without disturbing the parallel outputs, then update all of them together with a single storage pulse.

The parallel outputs come from the storage register. They carry a data word and a drive-enable flag that stands in for a high-impedance state. The last shift stage also leaves the block as a serial cascade output. Feeding it into the serial input of a second instance, with shared clocks, makes a longer register. An active-low clear empties the shift chain at once, without waiting for a clock. It leaves the storage register alone. If both clocks are driven from one net, the storage register captures the chain as it stood before that edge, so it stays one shift behind.

Top module: `sipo_latch`

## Requirements
- R1: On each rising edge of `shift_clk` with `clr_n` high, shift stage 0 takes `ser_in` and each stage i>0 takes the old value of stage i-1. Stage i maps to bit i of the parallel word.
- R2: While `clr_n` is low, every shift stage reads zero, whatever either clock does. The clear acts without a clock edge and overrides a shift edge that falls inside it.
- R3: On a rising edge of `store_clk`, all shift stages are copied at once into the storage register, which `par_data` shows. Between storage edges `par_data` holds, even while shifting goes on.
- R4: `par_drive` is 1 while `out_en_n` is 0 and 0 (outputs floating) while `out_en_n` is 1. It follows the pin without a clock. The enable changes neither `par_data` nor the shift contents.
- R5: `ser_out` always equals the last shift stage. It does not depend on the storage register or on `out_en_n`.
- R6: Asserting `clr_n` leaves the storage register unchanged. `par_data` keeps its value until the next `store_clk` edge.
- R7: When `shift_clk` and `store_clk` rise together, the storage register receives the shift contents from before that edge.
- R8: The stage count is the parameter `STAGES` (default 8). Two instances chained from `ser_out` to `ser_in`, with shared clocks, behave as one register of 2*STAGES stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| shift_clk | input | 1 | Shift clock, rising edge |
| store_clk | input | 1 | Storage clock, rising edge |
| clr_n | input | 1 | Asynchronous clear of the shift stages, active low |
| ser_in | input | 1 | Serial data input |
| out_en_n | input | 1 | Parallel output enable, active low |
| par_data | output | STAGES | Storage register contents |
| par_drive | output | 1 | 1 when the parallel outputs are driven, 0 when floating |
| ser_out | output | 1 | Serial cascade output, last shift stage |

## Verification
Both clocks are gated copies of the bench clock, so every shift or storage edge falls on a rising edge of that clock. The new shift contents and the cascade output are valid one register later, at the same edge, and the storage word is valid at the storage edge. The enable flag is valid with no delay at all. The driver changes inputs on the falling edge and queues the expected values after the pulse. The monitor compares them a short time after that falling edge, well away from any rising edge. The parallel word is compared only once a storage load has taken place, since the storage register has no defined value before that.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  // Default number of shift and storage stages.
  localparam int unsigned SIPO_STAGES_DEF = 8;
  // Smallest legal stage count (stage links need a predecessor).
  localparam int unsigned SIPO_STAGES_MIN = 2;
endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
  parameter int unsigned STAGES = 8
) (
  input  logic              shift_clk,
  input  logic              clr_n,
  input  logic              din,
  output logic [STAGES-1:0] stages
);
  localparam int unsigned LAST = STAGES - 1;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic d_in;
      if (i == 0) begin : g_head
        assign d_in = din;
      end else begin : g_link
        assign d_in = stages[i-1];
      end
      always_ff @(posedge shift_clk or negedge clr_n) begin
        if (!clr_n) stages[i] <= 1'b0;
        else        stages[i] <= d_in;
      end
    end
  endgenerate

  // R1
  shift_move_chk: assert property (@(posedge shift_clk) disable iff (!clr_n)
    1'b1 |=> (stages[LAST:1] == $past(stages[LAST-1:0])) && (stages[0] == $past(din)));

  // R2
  clear_empty_chk: assert property (@(posedge shift_clk)
    !clr_n |-> (stages == '0));

  // R2
  clear_release_chk: assert property (@(posedge shift_clk) disable iff (!clr_n)
    $past(!clr_n) |-> (stages[LAST:1] == '0));
endmodule

// File: rtl/sipo_store_reg.sv
module sipo_store_reg #(
  parameter int unsigned STAGES = 8
) (
  input  logic              store_clk,
  input  logic [STAGES-1:0] d,
  output logic [STAGES-1:0] q
);
  always_ff @(posedge store_clk) begin
    q <= d;
  end
endmodule

// File: rtl/sipo_out_gate.sv
module sipo_out_gate #(
  parameter int unsigned STAGES = 8
) (
  input  logic              out_en_n,
  input  logic [STAGES-1:0] store_q,
  output logic [STAGES-1:0] par_data,
  output logic              par_drive
);
  always_comb begin
    par_data  = store_q;
    par_drive = ~out_en_n;
  end
endmodule

// File: rtl/sipo_latch.sv
module sipo_latch
  import sipo_pkg::*;
#(
  parameter int unsigned STAGES = SIPO_STAGES_DEF
) (
  input  logic              shift_clk,
  input  logic              store_clk,
  input  logic              clr_n,
  input  logic              ser_in,
  input  logic              out_en_n,
  output logic [STAGES-1:0] par_data,
  output logic              par_drive,
  output logic              ser_out
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] store_q;

  sipo_shift_chain #(.STAGES(STAGES)) u_chain (
    .shift_clk (shift_clk),
    .clr_n     (clr_n),
    .din       (ser_in),
    .stages    (chain_q)
  );

  sipo_store_reg #(.STAGES(STAGES)) u_store (
    .store_clk (store_clk),
    .d         (chain_q),
    .q         (store_q)
  );

  sipo_out_gate #(.STAGES(STAGES)) u_out (
    .out_en_n  (out_en_n),
    .store_q   (store_q),
    .par_data  (par_data),
    .par_drive (par_drive)
  );

  assign ser_out = chain_q[LAST];

  initial begin
    // R8
    stage_count_chk: assert (STAGES >= SIPO_STAGES_MIN);
  end

  // R3
  store_copy_chk: assert property (@(posedge store_clk) disable iff (!clr_n)
    1'b1 |=> par_data == $past(chain_q));

  // R5
  cascade_tail_chk: assert property (@(posedge store_clk) disable iff (!clr_n)
    1'b1 |=> par_data[LAST] == $past(ser_out));
endmodule

// File: tb/sipo_latch_test.sv
module sipo_latch_test;
  localparam int unsigned N = 8;
  localparam int unsigned W = 2 * N;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic sh_go = 1'b0, st_go = 1'b0;
  logic shift_clk, store_clk;
  assign shift_clk = clk & sh_go;
  assign store_clk = clk & st_go;

  logic clr_n = 1'b1;
  logic ser_in = 1'b0;
  logic out_en_n = 1'b0;
  logic [N-1:0] lo_data, hi_data;
  logic lo_drive, hi_drive, lo_ser, hi_ser;

  sipo_latch #(.STAGES(N)) uut (
    .shift_clk(shift_clk), .store_clk(store_clk), .clr_n(clr_n),
    .ser_in(ser_in), .out_en_n(out_en_n),
    .par_data(lo_data), .par_drive(lo_drive), .ser_out(lo_ser));

  sipo_latch #(.STAGES(N)) u_hi (
    .shift_clk(shift_clk), .store_clk(store_clk), .clr_n(clr_n),
    .ser_in(lo_ser), .out_en_n(out_en_n),
    .par_data(hi_data), .par_drive(hi_drive), .ser_out(hi_ser));

  typedef struct {
    string        req;
    logic [W-1:0] data;
    logic         data_ok;
    logic         drive;
    logic         tail_lo;
    logic         tail_hi;
  } exp_t;

  exp_t exp_q[$];
  int n_cmp = 0, n_bad = 0;
  logic [W-1:0] m_sh = '0, m_st = '0;
  logic m_st_ok = 1'b0;
  bit done = 1'b0;

  task automatic push(input string req);
    exp_t e;
    e.req = req; e.data = m_st; e.data_ok = m_st_ok;
    e.drive = ~out_en_n; e.tail_lo = m_sh[N-1]; e.tail_hi = m_sh[W-1];
    exp_q.push_back(e);
  endtask

  // One clock slot: optional shift and/or storage edge.
  task automatic tick(input bit sh, input bit st, input bit d);
    @(negedge clk);
    ser_in = d; sh_go = sh; st_go = st;
    @(negedge clk);
    sh_go = 1'b0; st_go = 1'b0;
    if (st) begin m_st = m_sh; m_st_ok = 1'b1; end
    if (sh) m_sh = {m_sh[W-2:0], d};
  endtask

  // Clear held across a shift edge (clear must win).
  task automatic clear_all();
    @(negedge clk);
    clr_n = 1'b0; sh_go = 1'b1; ser_in = 1'b1;
    @(negedge clk);
    sh_go = 1'b0; m_sh = '0;
    @(negedge clk);
    clr_n = 1'b1;
  endtask

  task automatic shift_word(input logic [W-1:0] w, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) tick(1'b1, 1'b0, w[i]);
  endtask

  // Monitor: compares queued expectations shortly after a falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_cmp++;
        if (lo_ser !== e.tail_lo || hi_ser !== e.tail_hi) begin
          n_bad++;
          $display("FAIL %s cascade got %b/%b expected %b/%b", e.req, lo_ser, hi_ser, e.tail_lo, e.tail_hi);
        end
        if (lo_drive !== e.drive || hi_drive !== e.drive) begin
          n_bad++;
          $display("FAIL %s drive got %b/%b expected %b", e.req, lo_drive, hi_drive, e.drive);
        end
        if (e.data_ok && {hi_data, lo_data} !== e.data) begin
          n_bad++;
          $display("FAIL %s data got %h expected %h", e.req, {hi_data, lo_data}, e.data);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #1;
    clr_n = 1'b0;
    @(negedge clk);
    clr_n = 1'b1;
    m_sh = '0;
    push("R2 reset state");

    // R1 / R5: single one walks to the tail of the low instance
    tick(1'b1, 1'b0, 1'b1);
    push("R1 first bit");
    for (int i = 1; i < N; i++) tick(1'b1, 1'b0, 1'b0);
    push("R5 tail of first instance");

    // R3: store a known word
    clear_all();
    shift_word(16'h00A5, N);
    tick(1'b0, 1'b1, 1'b0);
    push("R3 store pattern A5");

    // R3: shifting alone leaves storage
    shift_word(16'h003C, 4);
    push("R3 storage held while shifting");

    // R4: outputs float, data and cascade unchanged
    @(negedge clk); out_en_n = 1'b1;
    #1 push("R4 disabled");
    tick(1'b0, 1'b1, 1'b0);
    push("R4 store while disabled");
    @(negedge clk); out_en_n = 1'b0;
    #1 push("R4 enabled again");

    // R6: clear keeps storage, empties chain
    clear_all();
    push("R6 storage survives clear");
    push("R2 chain empty after clear");

    // R8: 16-stage chain
    shift_word(16'hC3A9, W);
    tick(1'b0, 1'b1, 1'b0);
    push("R8 chained 16 stages");
    shift_word(16'h5E71, W);
    tick(1'b0, 1'b1, 1'b0);
    push("R8 chained second word");

    // R7: tied clocks, storage one shift behind
    clear_all();
    shift_word(16'h0001, 3);
    tick(1'b1, 1'b1, 1'b1);
    push("R7 tied edge stores old contents");
    tick(1'b1, 1'b1, 1'b0);
    push("R7 tied edge again");

    // R5: cascade independent of enable
    @(negedge clk); out_en_n = 1'b1;
    shift_word(16'hFFFF, W);
    push("R5 cascade while disabled");
    @(negedge clk); out_en_n = 1'b0;

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule